// File: doc/BRIEF.md
# Segmented Streaming Memory Block

This block is a small on-array memory with one controller that can run it in one of three ways: as a plain random-access store addressed token by token, as a stream source that plays tokens out of consecutive addresses, or as a stream sink that captures an incoming token stream into consecutive addresses. Only one of these uses is active at a time, so the block serves at most one stream. Software picks the use, the token width (8, 16 or 32 bits) and a lower and an upper token address through a small configuration write port.

Every address the block touches, whether it comes from the random-access port or from the internal sequential pointer, is checked against the segment limits and against the capacity for the chosen width. An out-of-segment access is dropped and raises a sticky fault level with the offending address, no matter whether a handshake was under way. A typical use is to park a stream between two producers and consumers that are never active together: capture it in sink mode, then switch to source mode and replay exactly the captured number of tokens, after which an end-of-data level is raised.

Top module: `seg_stream_mem`

## Requirements
- R1: After reset the fault level, the stream ready and valid outputs, the end-of-data level and the random read data are all 0; the mode is idle, width code 2 (32 bits), both limits 0.
- R2: In random mode (configuration register 0, bits [1:0] = 1) a write with `accEn`/`accWe` stores the token at `accAddr`; a read with `accEn` and `accWe` low loads `accRdata` on that clock edge, visible the cycle after.
- R3: Register 0 bits [3:2] select the token width (0 = 8, 1 = 16, 2 or 3 = 32 bits); token index t covers bytes t*n to t*n+n-1 of a byte store, least significant byte at the lowest byte address; a write changes only those n bytes and a read returns them zero-extended; capacity is MEM_BYTES/n tokens.
- R4: A token address is legal only if lower <= addr <= upper (registers 1 and 2) and addr is below the capacity; an illegal random access writes nothing, leaves `accRdata` unchanged and raises `fault` on the next cycle with `faultAddr` equal to that address.
- R5: The fault is sticky: while it is high the first fault address is held and no memory write, random read or stream transfer takes place; a configuration write to register 3 clears it.
- R6: Writing register 0 with mode 3 (sequential write) sets the pointer to the lower limit and the token count to 0; `sinkReady` is high while the pointer is legal and no fault is pending; each accepted token is stored at the pointer, which then advances by one, and the count increments.
- R7: In either streaming mode, a pointer that has left the segment while work is pending (sink: `sinkValid` high; source: tokens remaining) raises the fault with `faultAddr` equal to the pointer, and the token is neither accepted nor sent.
- R8: Writing register 0 with mode 2 (sequential read) sets the pointer to the lower limit and the remaining count to the last captured count; `srcValid` is high with `srcData` equal to the token at the pointer, and data and valid hold while `srcReady` is low; each transfer advances the pointer.
- R9: In sequential-read mode, once no tokens remain `eod` is high and `srcValid` is low.
- R10: In idle mode (bits [1:0] = 0) stream and random-access inputs have no effect: `sinkReady` and `srcValid` stay low and memory content is unchanged.
- R11: A stream captured in sequential-write mode and replayed in sequential-read mode over the same segment comes out with the same tokens in the same order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | Register select: 0 mode/width, 1 lower limit, 2 upper limit, 3 fault clear |
| cfgWdata | input | PTR_W | Configuration write data |
| accEn | input | 1 | Random access request |
| accWe | input | 1 | Random access is a write |
| accAddr | input | PTR_W | Random access token address |
| accWdata | input | 32 | Random write token |
| accRdata | output | 32 | Random read token, registered |
| sinkValid | input | 1 | Incoming stream token present |
| sinkReady | output | 1 | Block accepts the incoming token |
| sinkData | input | 32 | Incoming stream token |
| srcValid | output | 1 | Outgoing stream token present |
| srcReady | input | 1 | Consumer accepts the outgoing token |
| srcData | output | 32 | Outgoing stream token |
| fault | output | 1 | Sticky segment violation level |
| faultAddr | output | PTR_W | Token address of the first violation |
| eod | output | 1 | Replay finished in sequential-read mode |

## Verification
A wrong pointer or count shows within one cycle as a wrong `srcData` or an early or late `eod`, and a wrong limit comparison shows as a `sinkReady` or `fault` level that differs from the model on the very cycle the pointer reaches the segment edge. A missed suppression during a fault only shows later, when the protected location is read back, so the bench reads those locations directly after clearing the fault. Width decoding errors surface as wrong bytes in a read that straddles an earlier wider write.

// File: rtl/ssmem_pkg.sv
package ssmem_pkg;
  localparam int TOKEN_BITS = 32;
  localparam int LANES = TOKEN_BITS / 8;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_RAND  = 2'd1,
    MODE_SEQRD = 2'd2,
    MODE_SEQWR = 2'd3
  } mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic memWe;      // write a token at the presented address
    logic accLoad;    // capture a random read into the output register
    logic fromStream; // write data taken from the incoming stream
  } memStb_t;

  function automatic logic [1:0] widthShift(input logic [1:0] code);
    case (code)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/ssmem_ctrl.sv
module ssmem_ctrl
  import ssmem_pkg::*;
#(
  parameter int MEM_BYTES = 256,
  parameter int PTR_W = $clog2(MEM_BYTES) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [1:0]       cfgAddr,
  input  logic [PTR_W-1:0] cfgWdata,
  input  logic             accEn,
  input  logic             accWe,
  input  logic [PTR_W-1:0] accAddr,
  input  logic             sinkValid,
  input  logic             srcReady,
  output logic             sinkReady,
  output logic             srcValid,
  output logic             fault,
  output logic [PTR_W-1:0] faultAddr,
  output logic             eod,
  output logic [PTR_W-1:0] memAddr,
  output logic [1:0]       shift,
  output memStb_t          stb
);
  localparam logic [PTR_W-1:0] CAP_BYTES = PTR_W'(MEM_BYTES);

  mode_e            mode;
  logic [1:0]       widthCode;
  logic [PTR_W-1:0] lower, upper, ptr, count, left;
  logic [PTR_W-1:0] cap;
  logic             ptrOk, accOk;
  logic             sinkFire, srcFire, sinkFault, srcFault, accGo, accFault, newFault;

  function automatic logic inSegment(input logic [PTR_W-1:0] a,
                                     input logic [PTR_W-1:0] lo,
                                     input logic [PTR_W-1:0] hi,
                                     input logic [PTR_W-1:0] limit);
    return (a >= lo) && (a <= hi) && (a < limit);
  endfunction

  always_comb begin
    shift     = widthShift(widthCode);
    cap       = CAP_BYTES >> shift;
    ptrOk     = inSegment(ptr, lower, upper, cap);
    accOk     = inSegment(accAddr, lower, upper, cap);
    sinkReady = (mode == MODE_SEQWR) && !fault && ptrOk;
    srcValid  = (mode == MODE_SEQRD) && !fault && (left != '0) && ptrOk;
    sinkFire  = sinkValid && sinkReady;
    srcFire   = srcValid && srcReady;
    sinkFault = (mode == MODE_SEQWR) && !fault && sinkValid && !ptrOk;
    srcFault  = (mode == MODE_SEQRD) && !fault && (left != '0) && !ptrOk;
    accGo     = (mode == MODE_RAND) && !fault && accEn;
    accFault  = accGo && !accOk;
    newFault  = sinkFault || srcFault || accFault;
    eod       = (mode == MODE_SEQRD) && (left == '0);
    memAddr   = (mode == MODE_RAND) ? accAddr : ptr;
    stb.memWe      = sinkFire || (accGo && accOk && accWe);
    stb.accLoad    = accGo && accOk && !accWe;
    stb.fromStream = (mode == MODE_SEQWR);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode      <= MODE_IDLE;
      widthCode <= 2'd2;
      lower     <= '0;
      upper     <= '0;
      ptr       <= '0;
      count     <= '0;
      left      <= '0;
      fault     <= 1'b0;
      faultAddr <= '0;
    end else begin
      if (sinkFire) begin
        ptr   <= ptr + 1'b1;
        count <= count + 1'b1;
      end
      if (srcFire) begin
        ptr  <= ptr + 1'b1;
        left <= left - 1'b1;
      end
      if (cfgWe) begin
        case (cfgAddr)
          2'd0: begin
            mode      <= mode_e'(cfgWdata[1:0]);
            widthCode <= cfgWdata[3:2];
            ptr       <= lower;
            if (cfgWdata[1:0] == MODE_SEQWR) count <= '0;
            if (cfgWdata[1:0] == MODE_SEQRD) left <= count;
          end
          2'd1: lower <= cfgWdata;
          2'd2: upper <= cfgWdata;
          default: fault <= 1'b0;
        endcase
      end
      // a new violation wins over a clear in the same cycle
      if (newFault) begin
        fault     <= 1'b1;
        faultAddr <= memAddr;
      end
    end
  end
endmodule

// File: rtl/ssmem_dpath.sv
module ssmem_dpath
  import ssmem_pkg::*;
#(
  parameter int MEM_BYTES = 256,
  parameter int PTR_W = $clog2(MEM_BYTES) + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  memStb_t               stb,
  input  logic [1:0]            shift,
  input  logic [PTR_W-1:0]      addr,
  input  logic [TOKEN_BITS-1:0] accWdata,
  input  logic [TOKEN_BITS-1:0] sinkData,
  output logic [TOKEN_BITS-1:0] rdWord,
  output logic [TOKEN_BITS-1:0] accRdata
);
  localparam int BYTE_W = $clog2(MEM_BYTES);

  logic [7:0]            mem [MEM_BYTES];
  logic [BYTE_W-1:0]     byteBase;
  logic [LANES-1:0]      laneEn;
  logic [TOKEN_BITS-1:0] wrWord;

  always_comb begin
    byteBase = BYTE_W'({2'b00, addr} << shift);
    wrWord   = stb.fromStream ? sinkData : accWdata;
    for (int k = 0; k < LANES; k++) begin
      laneEn[k] = (k < (1 << shift));
    end
  end

  generate
    for (genvar g = 0; g < LANES; g++) begin : gLane
      always_comb rdWord[8*g +: 8] = laneEn[g] ? mem[byteBase + BYTE_W'(g)] : 8'h00;

      always_ff @(posedge clk) begin
        if (stb.memWe && laneEn[g]) mem[byteBase + BYTE_W'(g)] <= wrWord[8*g +: 8];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            accRdata <= '0;
    else if (stb.accLoad) accRdata <= rdWord;
  end
endmodule

// File: rtl/seg_stream_mem.sv
module seg_stream_mem
  import ssmem_pkg::*;
#(
  parameter int MEM_BYTES = 256,
  localparam int PTR_W = $clog2(MEM_BYTES) + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWe,
  input  logic [1:0]            cfgAddr,
  input  logic [PTR_W-1:0]      cfgWdata,
  input  logic                  accEn,
  input  logic                  accWe,
  input  logic [PTR_W-1:0]      accAddr,
  input  logic [TOKEN_BITS-1:0] accWdata,
  output logic [TOKEN_BITS-1:0] accRdata,
  input  logic                  sinkValid,
  output logic                  sinkReady,
  input  logic [TOKEN_BITS-1:0] sinkData,
  output logic                  srcValid,
  input  logic                  srcReady,
  output logic [TOKEN_BITS-1:0] srcData,
  output logic                  fault,
  output logic [PTR_W-1:0]      faultAddr,
  output logic                  eod
);
  memStb_t          stb;
  logic [PTR_W-1:0] memAddr;
  logic [1:0]       shift;

  ssmem_ctrl #(.MEM_BYTES(MEM_BYTES), .PTR_W(PTR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .accEn(accEn), .accWe(accWe), .accAddr(accAddr), .sinkValid(sinkValid),
    .srcReady(srcReady), .sinkReady(sinkReady), .srcValid(srcValid), .fault(fault),
    .faultAddr(faultAddr), .eod(eod), .memAddr(memAddr), .shift(shift), .stb(stb)
  );

  ssmem_dpath #(.MEM_BYTES(MEM_BYTES), .PTR_W(PTR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .shift(shift), .addr(memAddr),
    .accWdata(accWdata), .sinkData(sinkData), .rdWord(srcData), .accRdata(accRdata)
  );
endmodule

// File: rtl/seg_stream_mem_chk.sv
module seg_stream_mem_chk #(
  parameter int PTR_W = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgWe,
  input logic [1:0]       cfgAddr,
  input logic             srcValid,
  input logic             srcReady,
  input logic [31:0]      srcData,
  input logic             sinkReady,
  input logic             fault,
  input logic [PTR_W-1:0] faultAddr,
  input logic             eod
);
  a_r5_fault_freezes_stream: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> (!sinkReady && !srcValid));

  a_r5_fault_addr_held: assert property (@(posedge clk) disable iff (!rstN)
    (fault && !(cfgWe && cfgAddr == 2'd3)) |=> (fault && $stable(faultAddr)));

  a_r9_eod_blocks_valid: assert property (@(posedge clk) disable iff (!rstN)
    eod |-> !srcValid);

  a_r8_backpressure_hold: assert property (@(posedge clk) disable iff (!rstN)
    (srcValid && !srcReady && !cfgWe) |=> (srcValid && $stable(srcData)));

  a_r6_single_stream: assert property (@(posedge clk) disable iff (!rstN)
    !(srcValid && sinkReady));
endmodule

bind seg_stream_mem seg_stream_mem_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .srcValid(srcValid),
  .srcReady(srcReady), .srcData(srcData), .sinkReady(sinkReady), .fault(fault),
  .faultAddr(faultAddr), .eod(eod)
);

// File: tb/seg_stream_mem_tb.sv
`timescale 1ns/1ps
module seg_stream_mem_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgAddr = '0;
  logic [8:0]  cfgWdata = '0;
  logic        accEn = 1'b0, accWe = 1'b0;
  logic [8:0]  accAddr = '0;
  logic [31:0] accWdata = '0, accRdata;
  logic        sinkValid = 1'b0, sinkReady;
  logic [31:0] sinkData = '0;
  logic        srcValid, srcReady = 1'b0;
  logic [31:0] srcData;
  logic        fault, eod;
  logic [8:0]  faultAddr;

  always #5 clk = ~clk;

  seg_stream_mem u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .accEn(accEn), .accWe(accWe), .accAddr(accAddr), .accWdata(accWdata), .accRdata(accRdata),
    .sinkValid(sinkValid), .sinkReady(sinkReady), .sinkData(sinkData),
    .srcValid(srcValid), .srcReady(srcReady), .srcData(srcData),
    .fault(fault), .faultAddr(faultAddr), .eod(eod)
  );

  int checks = 0, fails = 0;
  bit live = 0;
  logic [31:0] got[$];

  task automatic chkEq(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit [7:0] mMem [256];
  int mMode, mW, mLo, mHi, mPtr, mCnt, mLeft, mFa;
  bit mFlt;
  longint mAcc;

  function automatic int shOf();
    return (mW == 0) ? 0 : (mW == 1) ? 1 : 2;
  endfunction
  function automatic bit mLegal(int a);
    return a >= mLo && a <= mHi && a < (256 >> shOf());
  endfunction
  function automatic longint mRead(int a);
    longint v = 0;
    for (int k = 0; k < (1 << shOf()); k++) v |= longint'(mMem[((a << shOf()) + k) % 256]) << (8 * k);
    return v;
  endfunction
  function automatic void mWrite(int a, logic [31:0] d);
    for (int k = 0; k < (1 << shOf()); k++) mMem[((a << shOf()) + k) % 256] = d[8*k +: 8];
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 0; mW = 2; mLo = 0; mHi = 0; mPtr = 0; mCnt = 0; mLeft = 0;
      mFlt = 0; mFa = 0; mAcc = 0;
    end else begin
      automatic bit okP = mLegal(mPtr);
      automatic bit okA = mLegal(int'(accAddr));
      automatic int p0 = mPtr, mode0 = mMode;
      automatic bit sFire = mMode == 3 && !mFlt && okP && sinkValid;
      automatic bit sFlt  = mMode == 3 && !mFlt && !okP && sinkValid;
      automatic bit rFire = mMode == 2 && !mFlt && mLeft > 0 && okP && srcReady;
      automatic bit rFlt  = mMode == 2 && !mFlt && mLeft > 0 && !okP;
      automatic bit aGo   = mMode == 1 && !mFlt && accEn;
      if (sFire) begin mWrite(mPtr, sinkData); mPtr++; mCnt++; end
      if (rFire) begin mPtr++; mLeft--; end
      if (aGo && okA) begin
        if (accWe) mWrite(int'(accAddr), accWdata);
        else mAcc = mRead(int'(accAddr));
      end
      if (cfgWe) begin
        case (cfgAddr)
          2'd0: begin
            mMode = int'(cfgWdata[1:0]); mW = int'(cfgWdata[3:2]); mPtr = mLo;
            if (mMode == 3) mCnt = 0;
            if (mMode == 2) mLeft = mCnt;
          end
          2'd1: mLo = int'(cfgWdata);
          2'd2: mHi = int'(cfgWdata);
          default: mFlt = 0;
        endcase
      end
      if (sFlt || rFlt || (aGo && !okA)) begin
        mFlt = 1;
        mFa = (mode0 == 1) ? int'(accAddr) : p0;
      end
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (live) begin
      automatic bit expSink = mMode == 3 && !mFlt && mLegal(mPtr);
      automatic bit expSrc  = mMode == 2 && !mFlt && mLeft > 0 && mLegal(mPtr);
      chkEq("R6", "sinkReady", sinkReady, expSink);
      chkEq("R8", "srcValid", srcValid, expSrc);
      if (expSrc) chkEq("R11", "srcData", srcData, mRead(mPtr));
      chkEq("R4", "fault", fault, mFlt);
      if (mFlt) chkEq("R5", "faultAddr", faultAddr, mFa);
      chkEq("R9", "eod", eod, mMode == 2 && mLeft == 0);
      chkEq("R2", "accRdata", accRdata, mAcc);
      if (srcValid && srcReady) got.push_back(srcData);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(posedge clk); #1;
  endtask
  task automatic cfgWr(int a, int d);
    cfgWe = 1; cfgAddr = 2'(a); cfgWdata = 9'(d); step(); cfgWe = 0;
  endtask
  task automatic accW(int a, logic [31:0] d);
    accEn = 1; accWe = 1; accAddr = 9'(a); accWdata = d; step(); accEn = 0; accWe = 0;
  endtask
  task automatic accR(int a);
    accEn = 1; accWe = 0; accAddr = 9'(a); step(); accEn = 0;
  endtask
  task automatic pushTok(logic [31:0] d);
    sinkValid = 1; sinkData = d; step(); sinkValid = 0;
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1; live = 1;
    @(negedge clk);
    chkEq("R1", "fault", fault, 0);
    chkEq("R1", "sinkReady", sinkReady, 0);
    chkEq("R1", "srcValid", srcValid, 0);
    chkEq("R1", "eod", eod, 0);
    chkEq("R1", "accRdata", accRdata, 0);
    step();

    // fill the store so byte k holds value k (32-bit tokens, full segment)
    cfgWr(2, 63);
    cfgWr(0, 1 | (2 << 2));
    for (int i = 0; i < 64; i++) accW(i, {8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)});

    // R10: idle mode ignores access and stream inputs
    cfgWr(0, 0 | (2 << 2));
    accW(1, 32'hDEAD_BEEF);
    sinkValid = 1; sinkData = 32'h55;
    @(negedge clk);
    chkEq("R10", "sinkReady in idle", sinkReady, 0);
    chkEq("R10", "srcValid in idle", srcValid, 0);
    step(); sinkValid = 0;
    cfgWr(0, 1 | (2 << 2));
    accR(1);
    @(negedge clk); chkEq("R10", "token 1 unchanged", accRdata, 32'h0706_0504);
    step();

    // R2: random write and read
    accW(7, 32'hCAFE_F00D);
    accR(7);
    @(negedge clk); chkEq("R2", "readback token 7", accRdata, 32'hCAFE_F00D);
    step();
    accR(2);
    @(negedge clk); chkEq("R2", "readback token 2", accRdata, 32'h0B0A_0908);
    step();

    // R3: width selection
    cfgWr(0, 1 | (0 << 2));
    accR(29);
    @(negedge clk); chkEq("R3", "8-bit token 29", accRdata, 32'hF0);
    step();
    cfgWr(0, 1 | (1 << 2));
    accW(5, 32'h1234_ABCD);
    accR(5);
    @(negedge clk); chkEq("R3", "16-bit token 5", accRdata, 32'hABCD);
    step();
    cfgWr(0, 1 | (2 << 2));
    accR(2);
    @(negedge clk); chkEq("R3", "32-bit token 2 after 16-bit write", accRdata, 32'hABCD_0908);
    step();

    // R4: out-of-segment random read
    cfgWr(1, 4); cfgWr(2, 10);
    accR(11);
    @(negedge clk);
    chkEq("R4", "fault after read at 11", fault, 1);
    chkEq("R4", "faultAddr", faultAddr, 11);
    chkEq("R4", "accRdata unchanged", accRdata, 32'hABCD_0908);
    step();

    // R5: sticky fault suppresses accesses, first address held
    accW(5, 32'h1111_1111);
    accW(12, 32'h2222_2222);
    @(negedge clk); chkEq("R5", "faultAddr held", faultAddr, 11);
    step();
    cfgWr(3, 0);
    @(negedge clk); chkEq("R5", "fault cleared", fault, 0);
    step();
    accR(5);
    @(negedge clk); chkEq("R5", "write during fault suppressed", accRdata, 32'h1716_1514);
    step();

    // R4: illegal write has no effect
    accW(2, 32'h9999_9999);
    @(negedge clk); chkEq("R4", "faultAddr for write at 2", faultAddr, 2);
    step();
    cfgWr(3, 0); cfgWr(1, 0);
    accR(2);
    @(negedge clk); chkEq("R4", "token 2 not written", accRdata, 32'hABCD_0908);
    step();

    // R6/R7: capture 16-bit stream into tokens 8..11, overflow at 12
    cfgWr(1, 8); cfgWr(2, 11);
    cfgWr(0, 3 | (1 << 2));
    pushTok(32'h1111); pushTok(32'h2222); step();
    pushTok(32'h3333); pushTok(32'h4444); pushTok(32'h5555);
    @(negedge clk);
    chkEq("R7", "sink overflow fault", fault, 1);
    chkEq("R7", "sink overflow address", faultAddr, 12);
    chkEq("R7", "sinkReady low", sinkReady, 0);
    step();
    cfgWr(3, 0);

    // R8/R9/R11: replay with back-pressure
    got.delete();
    cfgWr(0, 2 | (1 << 2));
    step(); step();
    @(negedge clk);
    chkEq("R8", "first token presented", srcData, 32'h1111);
    chkEq("R8", "valid under back-pressure", srcValid, 1);
    step();
    srcReady = 1; step(); step();
    srcReady = 0; step(); step();
    srcReady = 1; repeat (4) step();
    srcReady = 0;
    @(negedge clk);
    chkEq("R9", "eod after replay", eod, 1);
    chkEq("R9", "srcValid after replay", srcValid, 0);
    chkEq("R11", "replay count", got.size(), 4);
    if (got.size() == 4) begin
      chkEq("R11", "replay token 0", got[0], 32'h1111);
      chkEq("R11", "replay token 3", got[3], 32'h4444);
    end
    step();
    cfgWr(0, 1 | (1 << 2));
    accR(9);
    @(negedge clk); chkEq("R6", "captured token at pointer 9", accRdata, 32'h2222);
    step();

    // R7: source pointer leaves a shrunk segment with tokens pending
    cfgWr(1, 0); cfgWr(2, 20);
    cfgWr(0, 3 | (2 << 2));
    pushTok(32'hA0A0_0001); pushTok(32'hA0A0_0002); pushTok(32'hA0A0_0003);
    cfgWr(2, 1);
    got.delete();
    cfgWr(0, 2 | (2 << 2));
    srcReady = 1; repeat (4) step(); srcReady = 0;
    @(negedge clk);
    chkEq("R7", "source overflow fault", fault, 1);
    chkEq("R7", "source overflow address", faultAddr, 2);
    chkEq("R7", "tokens sent before fault", got.size(), 2);
    step();
    cfgWr(0, 0);
    cfgWr(3, 0);
    step();

    live = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule